// File: doc/BRIEF.md
# Single-Precision Compare Flag Generator

This block orders two packed single-precision words, D and M, and turns the outcome into four condition flags (N, Z, C, V) plus an invalid-operation flag. It works directly on the packed encodings and never unpacks either word into a wider internal format. Zeros are handled by a magnitude check. Operands of equal sign are ordered by an integer comparison of the whole word, and that comparison is reversed when both operands are negative.

Two controls select the variant. A signal-on-quiet control makes any NaN raise invalid; without it, only a signalling NaN raises invalid. A compare-with-zero control substitutes +0 for M, so M has no effect. The flags are registered, and each result appears one clock after its operands are presented. Storing the flags in a status register is left to the surrounding logic.

Top module: `sp_compare_flags`

## Requirements
- R1: While `rst` is high at a rising edge, all five flag outputs are 0 after that edge.
- R2: A word is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. If either compared operand is a NaN, the result is unordered: {N,Z,C,V} = 0011.
- R3: A NaN whose bit 22 is 0 is signalling and always sets `flag_invalid`. A NaN whose bit 22 is 1 is quiet and sets `flag_invalid` only when `signal_quiet` is 1. With no NaN present, `flag_invalid` is 0.
- R4: When the bitwise OR of the two operands has zero in bits 30:0, the operands compare equal ({N,Z,C,V} = 0110), whatever their sign bits. Equal words also give 0110.
- R5: When the sign bits (bit 31) differ and the operands are not equal, the operand with bit 31 set is the smaller. D smaller gives 1000; D greater gives 0010.
- R6: When the sign bits match and the operands are not equal, D is smaller exactly when the unsigned comparison D < M gives the opposite of D's sign bit. D smaller gives 1000; otherwise the result is 0010.
- R7: When `zero_mode` is 1, the second operand is +0 (0x00000000) and `op_m` has no effect on any flag, including a NaN on `op_m`.
- R8: With no NaN present, V is 0 and exactly one of the patterns 1000, 0110, 0010 is produced.
- R9: The outputs after a rising edge reflect the inputs sampled at that edge. They hold their values until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_d | input | 32 | First operand D, packed single precision |
| op_m | input | 32 | Second operand M, packed single precision |
| signal_quiet | input | 1 | 1: quiet NaNs also raise invalid |
| zero_mode | input | 1 | 1: compare D against +0 instead of M |
| flag_n | output | 1 | Registered N flag (less than) |
| flag_z | output | 1 | Registered Z flag (equal) |
| flag_c | output | 1 | Registered C flag (equal, greater or unordered) |
| flag_v | output | 1 | Registered V flag (unordered) |
| flag_invalid | output | 1 | Registered invalid-operation flag |

## Verification
The hardest cases to reach are on the boundaries of the packed encoding: signalling NaNs, whose nonzero payload has its top bit clear; -0 against +0; and neighbouring words of the same negative sign, where the integer order must be reversed. Uniform random words almost never land on these. The stimulus therefore draws each operand from weighted classes (quiet NaN, signalling NaN, infinity, signed zero, denormal, arbitrary), and often makes M equal to D or to D with only its lowest bit flipped. Directed cases add zero mode with a NaN on M and a hold check between edges.

// File: rtl/spcmp_pkg.sv
`timescale 1ns/1ps
package spcmp_pkg;
    parameter int EXP_W  = 8;
    parameter int MAN_W  = 23;
    localparam int WORD_W = 1 + EXP_W + MAN_W;

    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2,
        ORD_UN = 2'd3
    } order_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        nzcv_t flags;
        logic  invalid;
    } cmp_result_t;

    // Map an ordering outcome onto its condition-flag pattern
    function automatic nzcv_t flags_of(input order_e ord);
        nzcv_t f;
        f = '0;
        case (ord)
            ORD_LT: f.n = 1'b1;
            ORD_EQ: begin f.z = 1'b1; f.c = 1'b1; end
            ORD_GT: f.c = 1'b1;
            default: begin f.c = 1'b1; f.v = 1'b1; end
        endcase
        return f;
    endfunction
endpackage

// File: rtl/spcmp_operand_class.sv
`timescale 1ns/1ps
module spcmp_operand_class #(
    parameter int EXP_W = spcmp_pkg::EXP_W,
    parameter int MAN_W = spcmp_pkg::MAN_W,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] word,
    output logic         is_nan,
    output logic         is_snan
);
    logic exp_ones;
    logic man_nonzero;

    assign exp_ones    = &word[W-2:MAN_W];
    assign man_nonzero = |word[MAN_W-1:0];
    assign is_nan      = exp_ones & man_nonzero;
    // quiet marker is the top mantissa bit
    assign is_snan     = is_nan & ~word[MAN_W-1];
endmodule

// File: rtl/spcmp_order.sv
`timescale 1ns/1ps
module spcmp_order
    import spcmp_pkg::*;
#(
    parameter int W = spcmp_pkg::WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         unordered,
    output order_e       ord
);
    logic [W-1:0] or_w;
    logic         mag_zero;
    logic         int_lt;

    assign or_w     = a | b;
    assign mag_zero = ~|or_w[W-2:0];
    assign int_lt   = a < b;

    always_comb begin
        if (unordered) begin
            ord = ORD_UN;
        end else if ((a == b) || mag_zero) begin
            ord = ORD_EQ;
        end else if (a[W-1] != b[W-1]) begin
            ord = a[W-1] ? ORD_LT : ORD_GT;
        end else begin
            ord = (a[W-1] ^ int_lt) ? ORD_LT : ORD_GT;
        end
    end
endmodule

// File: rtl/sp_compare_flags.sv
`timescale 1ns/1ps
module sp_compare_flags
    import spcmp_pkg::*;
#(
    parameter int EXP_W = spcmp_pkg::EXP_W,
    parameter int MAN_W = spcmp_pkg::MAN_W,
    localparam int W    = 1 + EXP_W + MAN_W,
    localparam int NOPS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_d,
    input  logic [W-1:0] op_m,
    input  logic         signal_quiet,
    input  logic         zero_mode,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v,
    output logic         flag_invalid
);
    logic [NOPS-1:0][W-1:0] opnd;
    logic [NOPS-1:0]        nan_vec;
    logic [NOPS-1:0]        snan_vec;
    order_e                 ord;
    cmp_result_t            res_next;
    cmp_result_t            res_q;

    assign opnd[0] = op_d;
    assign opnd[1] = zero_mode ? '0 : op_m;

    for (genvar g = 0; g < NOPS; g++) begin : g_class
        spcmp_operand_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
            .word    (opnd[g]),
            .is_nan  (nan_vec[g]),
            .is_snan (snan_vec[g])
        );
    end

    spcmp_order #(.W(W)) u_order (
        .a         (opnd[0]),
        .b         (opnd[1]),
        .unordered (|nan_vec),
        .ord       (ord)
    );

    always_comb begin
        res_next.flags   = flags_of(ord);
        res_next.invalid = |(nan_vec & ({NOPS{signal_quiet}} | snan_vec));
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_next;
    end

    assign flag_n       = res_q.flags.n;
    assign flag_z       = res_q.flags.z;
    assign flag_c       = res_q.flags.c;
    assign flag_v       = res_q.flags.v;
    assign flag_invalid = res_q.invalid;
endmodule

// File: rtl/sp_compare_flags_chk.sv
`timescale 1ns/1ps
module sp_compare_flags_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] op_d,
    input logic [W-1:0] op_m,
    input logic         signal_quiet,
    input logic         zero_mode,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v,
    input logic         flag_invalid
);
    logic [W-1:0] eff_m;
    logic         d_nan, m_nan, d_sig, m_sig, any_nan, any_sig, both_zero;

    assign eff_m     = zero_mode ? '0 : op_m;
    assign d_nan     = (op_d[30:23] == 8'hFF) && (op_d[22:0] != 0);
    assign m_nan     = (eff_m[30:23] == 8'hFF) && (eff_m[22:0] != 0);
    assign d_sig     = d_nan && !op_d[22];
    assign m_sig     = m_nan && !eff_m[22];
    assign any_nan   = d_nan || m_nan;
    assign any_sig   = d_sig || m_sig;
    assign both_zero = (op_d[30:0] == 0) && (eff_m[30:0] == 0);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !(flag_n || flag_z || flag_c || flag_v || flag_invalid));

    // R2
    unordered_chk: assert property (@(posedge clk) disable iff (rst)
        any_nan |=> (!flag_n && !flag_z && flag_c && flag_v));

    // R3
    snan_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        any_sig |=> flag_invalid);

    // R3
    quiet_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (any_nan && !any_sig) |=> (flag_invalid == $past(signal_quiet)));

    // R3
    no_nan_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !any_nan |=> !flag_invalid);

    // R4
    signed_zero_eq_chk: assert property (@(posedge clk) disable iff (rst)
        both_zero |=> (flag_z && flag_c && !flag_n && !flag_v));

    // R7
    zero_mode_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_mode && !d_nan) |=> !flag_v);

    // R8
    ordered_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        !any_nan |=> (!flag_v && $onehot({flag_n, flag_z, flag_c && !flag_z})));
endmodule

bind sp_compare_flags sp_compare_flags_chk #(.W(32)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_d         (op_d),
    .op_m         (op_m),
    .signal_quiet (signal_quiet),
    .zero_mode    (zero_mode),
    .flag_n       (flag_n),
    .flag_z       (flag_z),
    .flag_c       (flag_c),
    .flag_v       (flag_v),
    .flag_invalid (flag_invalid)
);

// File: tb/sp_compare_flags_tb.sv
`timescale 1ns/1ps
module sp_compare_flags_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] op_d, op_m;
    logic        signal_quiet, zero_mode;
    logic        flag_n, flag_z, flag_c, flag_v, flag_invalid;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #2 clk = ~clk;

    sp_compare_flags u_dut (
        .clk(clk), .rst(rst), .op_d(op_d), .op_m(op_m),
        .signal_quiet(signal_quiet), .zero_mode(zero_mode),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .flag_v(flag_v), .flag_invalid(flag_invalid)
    );

    // Total-order key: larger key means larger value; both zeros share one key
    function automatic logic [31:0] order_key(input logic [31:0] w);
        if (w[30:0] == 0) return 32'h8000_0000;
        return w[31] ? ~w : {1'b1, w[30:0]};
    endfunction

    function automatic bit is_nan_w(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction

    // Expected {N,Z,C,V,invalid}
    function automatic logic [4:0] ref_flags(input logic [31:0] d, input logic [31:0] m,
                                             input logic sq, input logic zm);
        logic [31:0] b;
        logic        inv;
        b = zm ? 32'h0 : m;
        if (is_nan_w(d) || is_nan_w(b)) begin
            inv = (is_nan_w(d) && (sq || !d[22])) || (is_nan_w(b) && (sq || !b[22]));
            return {4'b0011, inv};
        end
        if (order_key(d) == order_key(b)) return 5'b01100;
        if (order_key(d) <  order_key(b)) return 5'b10000;
        return 5'b00100;
    endfunction

    function automatic string req_of(input logic [31:0] d, input logic [31:0] m, input logic zm);
        logic [31:0] b;
        b = zm ? 32'h0 : m;
        if (is_nan_w(d) || is_nan_w(b)) return "R2/R3";
        if (((d | b) & 32'h7FFF_FFFF) == 0) return "R4";
        if (d[31] != b[31]) return "R5";
        return "R6";
    endfunction

    function automatic logic [31:0] rand_word();
        logic s;
        s = 1'($urandom);
        case ($urandom % 8)
            0: return {s, 8'hFF, 1'b1, 22'($urandom)};
            1: return {s, 8'hFF, 1'b0, 22'($urandom) | 22'h1};
            2: return {s, 8'hFF, 23'h0};
            3: return {s, 31'h0};
            4: return {s, 8'h00, 23'($urandom)};
            default: return $urandom;
        endcase
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {flag_n, flag_z, flag_c, flag_v, flag_invalid};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: d=%h m=%h sq=%0b zm=%0b actual NZCVI=%b expected=%b",
                     req, op_d, op_m, signal_quiet, zero_mode, act, exp);
        end
    endtask

    // Drive at a falling edge, one rising edge registers, sample at next falling edge
    task automatic run(input logic [31:0] d, input logic [31:0] m,
                       input logic sq, input logic zm, input string req);
        @(negedge clk);
        op_d = d; op_m = m; signal_quiet = sq; zero_mode = zm;
        @(negedge clk);
        check(req, ref_flags(d, m, sq, zm));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; op_d = 32'h0; op_m = 32'h0; signal_quiet = 1'b0; zero_mode = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", 5'b00000);
        rst = 1'b0;

        run(32'h3F80_0000, 32'h3F80_0000, 1'b0, 1'b0, "R4 equal words");
        run(32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0, "R4 -0 vs +0");
        run(32'hBF80_0000, 32'h3F80_0000, 1'b0, 1'b0, "R5 neg<pos");
        run(32'h4000_0000, 32'hC000_0000, 1'b0, 1'b0, "R5 pos>neg");
        run(32'h3F80_0000, 32'h4000_0000, 1'b0, 1'b0, "R6 pos lt");
        run(32'hC000_0000, 32'hBF80_0000, 1'b0, 1'b0, "R6 neg inverted lt");
        run(32'hBF80_0000, 32'hBF80_0001, 1'b0, 1'b0, "R6 neg inverted gt");
        run(32'h7FC0_0000, 32'h3F80_0000, 1'b0, 1'b0, "R2 quiet nan no invalid");
        run(32'h7FC0_0000, 32'h3F80_0000, 1'b1, 1'b0, "R3 quiet nan signalling cmp");
        run(32'h3F80_0000, 32'h7F80_0001, 1'b0, 1'b0, "R3 signalling nan on M");
        run(32'h7F80_0000, 32'h7F80_0000, 1'b1, 1'b0, "R8 infinities equal");
        run(32'h3F80_0000, 32'h7F80_0001, 1'b0, 1'b1, "R7 nan on M ignored");
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, "R7 -0 vs zero");
        run(32'h8000_0001, 32'h0000_0000, 1'b0, 1'b1, "R7 neg denorm vs zero");

        // R9: before the next edge the outputs still hold the previous result
        @(negedge clk);
        op_d = 32'h4000_0000; op_m = 32'h3F80_0000; zero_mode = 1'b0; signal_quiet = 1'b0;
        #1 check("R9 hold before edge", 5'b10000);
        @(negedge clk);
        check("R9 update after edge", 5'b00100);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] d, m;
            logic        zm, sq;
            d = rand_word();
            case ($urandom % 4)
                0: m = d;
                1: m = d ^ 32'h1;
                default: m = rand_word();
            endcase
            sq = 1'($urandom);
            zm = (($urandom % 8) == 0);
            run(d, m, sq, zm, req_of(d, m, zm));
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", 5'b00000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule